// File: doc/BRIEF.md
# Host Memory Window Port

This block lets an external bus master reach a processor's internal memory one word at a time. The host first loads a 32-bit address register that carries a word pointer plus two control bits. It then writes or reads a data register. Each data-register access turns into exactly one single-word request on an internal request/acknowledge memory port, at the word address currently held.

A read of the data register stalls the host, with `hostReady` low, until the memory answers. The fetched word then sits in the data register for the host to pick up. In asynchronous mode the word pointer can step forward by one after each completed transfer, so a host can stream through memory without reloading the address. Bit 1 of the address register is an active-low enable for this stepping. Bit 0 lets the host raise an interrupt toward the processor, and only the processor's clear input can lower it again.

Top module: `host_mem_window`

## Requirements
- R1: After reset both registers are zero, `hostReady` is 1, `memReq` is 0 and `cpuIrq` is 0.
- R2: With `hostSel`=0, a host write loads the address register. Bits 31:2 are the word address, bit 1 is the increment-disable bit (1 = hold address) and bit 0 is the interrupt request. With `hostSel`=0, `hostRdata` returns the current word address in bits 31:2, the increment-disable bit in bit 1 and the live interrupt flag in bit 0, all in the same cycle.
- R3: A host write with `hostSel`=1 stores `hostWdata` in the data register. From the next cycle it raises `memReq` with `memWe`=1, `memAddr` equal to the word address and `memWdata` equal to the written word. `hostReady` is 0 from the cycle after the strobe until the cycle after `memAck`.
- R4: A host read with `hostSel`=1 raises `memReq` with `memWe`=0. The `memRdata` word present with `memAck` is captured, and once `hostReady` returns to 1 it appears on `hostRdata` while `hostSel`=1.
- R5: With `asyncMode`=1 and bit 1 clear, the word address grows by one on the cycle after each `memAck`. It wraps from 2^30-1 to 0.
- R6: With `asyncMode`=1 and bit 1 set, the word address is unchanged by a data transfer.
- R7: With `asyncMode`=0, the word address is never changed by a data transfer, whatever bit 1 holds.
- R8: An accepted address-register write with bit 0 set makes `cpuIrq` 1 on the next cycle. A write with bit 0 clear leaves `cpuIrq` unchanged.
- R9: A cycle with `irqClr`=1 makes `cpuIrq` 0 on the next cycle, unless an accepted host write sets bit 0 in the same cycle, in which case the set wins.
- R10: Host strobes that arrive while `hostReady` is 0 have no effect on either register, on the interrupt or on the memory port.
- R11: While `memReq` is 1 and `memAck` is 0, `memReq`, `memWe`, `memAddr` and `memWdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| asyncMode | input | 1 | 1 = asynchronous port mode (address stepping allowed) |
| hostSel | input | 1 | 0 = address register, 1 = data register |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for the selected register |
| hostReady | output | 1 | 1 = port idle and accepting strobes |
| memReq | output | 1 | Internal memory request, held until acknowledged |
| memWe | output | 1 | 1 = write request, 0 = read request |
| memAddr | output | 30 | Word address of the request |
| memWdata | output | 32 | Word to store |
| memRdata | input | 32 | Word returned by memory, valid with memAck |
| memAck | input | 1 | Memory completion, one cycle |
| cpuIrq | output | 1 | Interrupt toward the processor |
| irqClr | input | 1 | Processor-side clear of the interrupt flag |

## Verification
A wrong word pointer shows on `memAddr` at the very next transfer request. It also shows on an address-register read in the cycle after the acknowledge that should have stepped it, or should have left it alone. A stuck transfer state shows as `hostReady` staying low, or as `memReq` never dropping, within one cycle of the expected acknowledge. A lost or wrongly cleared interrupt flag shows on `cpuIrq` and on bit 0 of the address read one cycle after the host write or processor clear.

// File: rtl/hmw_pkg.sv
package hmw_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } hmwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;  // host writes address register
    logic setIrq;    // host requests interrupt
    logic loadData;  // host writes data register
    logic capture;   // memory read word arrives
    logic bump;      // step word pointer
  } hmwStrobe_t;

endpackage

// File: rtl/hmw_ctrl.sv
module hmw_ctrl
  import hmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asyncMode,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostIrqBit,
  input  logic       incOff,
  input  logic       memAck,
  output hmwStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       hostReady
);

  hmwState_e state;
  logic      weReg;
  logic      wrOk;
  logic      rdOk;
  logic      startXfer;
  logic      done;

  always_comb begin
    wrOk      = (state == ST_IDLE) && hostWr;
    rdOk      = (state == ST_IDLE) && hostRd && !hostWr;
    startXfer = (wrOk || rdOk) && hostSel;
    done      = (state == ST_BUSY) && memAck;

    strobe.loadAddr = wrOk && !hostSel;
    strobe.setIrq   = wrOk && !hostSel && hostIrqBit;
    strobe.loadData = wrOk && hostSel;
    strobe.capture  = done && !weReg;
    strobe.bump     = done && asyncMode && !incOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      weReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startXfer) begin
          state <= ST_BUSY;
          weReg <= hostWr;
        end
        ST_BUSY: if (memAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq    = (state == ST_BUSY);
  assign memWe     = weReg;
  assign hostReady = (state == ST_IDLE);

  // R3 / R4: an accepted data access opens a request of the right kind
  a_r3_start_request: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && hostSel && (hostWr || hostRd)) |=> (memReq && (memWe == $past(hostWr))));

  // R11: request and direction held until acknowledged
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R3: completion returns the port to ready
  a_r3_ready_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (hostReady && !memReq));

endmodule

// File: rtl/hmw_datapath.sv
module hmw_datapath
  import hmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmwStrobe_t        strobe,
  input  logic              irqClr,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-3:0] wordAddr,
  output logic              incOff,
  output logic              irqFlag,
  output logic [DATA_W-1:0] dataReg
);

  localparam int ADDR_W = DATA_W - 2;

  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      incOff  <= 1'b0;
    end else if (strobe.loadAddr) begin
      addrReg <= hostWdata[DATA_W-1:2];
      incOff  <= hostWdata[1];
    end else if (strobe.bump) begin
      addrReg <= addrReg + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               irqFlag <= 1'b0;
    else if (strobe.setIrq)  irqFlag <= 1'b1;
    else if (irqClr)         irqFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                dataReg <= '0;
    else if (strobe.loadData) dataReg <= hostWdata;
    else if (strobe.capture)  dataReg <= memRdata;
  end

  assign wordAddr  = addrReg;
  assign hostRdata = hostSel ? dataReg : {addrReg, incOff, irqFlag};

  // R9: processor clear lowers the flag unless a host set collides
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !strobe.setIrq) |=> !irqFlag);

  // R8: only the processor clear can lower the flag
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

endmodule

// File: rtl/host_mem_window.sv
module host_mem_window
  import hmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asyncMode,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostReady,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-3:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              cpuIrq,
  input  logic              irqClr
);

  localparam int ADDR_W = DATA_W - 2;

  hmwStrobe_t        strobe;
  logic              incOff;
  logic [ADDR_W-1:0] wordAddr;

  hmw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .asyncMode  (asyncMode),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostIrqBit (hostWdata[0]),
    .incOff     (incOff),
    .memAck     (memAck),
    .strobe     (strobe),
    .memReq     (memReq),
    .memWe      (memWe),
    .hostReady  (hostReady)
  );

  hmw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .irqClr    (irqClr),
    .hostSel   (hostSel),
    .hostWdata (hostWdata),
    .memRdata  (memRdata),
    .hostRdata (hostRdata),
    .wordAddr  (wordAddr),
    .incOff    (incOff),
    .irqFlag   (cpuIrq),
    .dataReg   (memWdata)
  );

  assign memAddr = wordAddr;

  // R5: asynchronous mode with stepping enabled advances by one word
  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && asyncMode && !incOff) |=> (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R7: synchronous mode never steps the pointer
  a_r7_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !asyncMode) |=> $stable(memAddr));

  // R11: address and write word stay put while waiting
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));

  // R8: the interrupt rises only from an accepted host write of bit 0
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuIrq) |-> $past(hostWr && !hostSel && hostWdata[0] && hostReady));

  // R9: the interrupt falls only through the processor clear
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuIrq) |-> $past(irqClr));

endmodule

// File: tb/host_mem_window_test.sv
`timescale 1ns/1ps
module host_mem_window_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        asyncMode = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady;
  logic        memReq;
  logic        memWe;
  logic [29:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        cpuIrq;
  logic        irqClr = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  host_mem_window uut (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .hostSel(hostSel),
    .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .cpuIrq(cpuIrq), .irqClr(irqClr)
  );

  // memory model: acknowledges after lat idle cycles
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      if (cnt >= lat) begin
        memAck = 1'b1;
        if (memWe) mem[memAddr[3:0]] = memWdata;
        else       memRdata = mem[memAddr[3:0]];
      end else begin
        cnt = cnt + 1;
      end
    end else begin
      memAck = 1'b0;
      cnt = 0;
    end
  end

  typedef struct packed {
    logic        am;
    logic        incOff;
    logic [29:0] addr;
    logic [31:0] data;
    logic [29:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 30'd5,          32'hA5A5_0001, 30'd6},
    '{1'b1, 1'b1, 30'd7,          32'h1234_5678, 30'd7},
    '{1'b0, 1'b0, 30'd9,          32'hDEAD_BEEF, 30'd9},
    '{1'b0, 1'b1, 30'd3,          32'h0F0F_F0F0, 30'd3},
    '{1'b1, 1'b0, 30'h3FFF_FFFF,  32'hCAFE_0042, 30'd0},
    '{1'b1, 1'b0, 30'd0,          32'h8000_0001, 30'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostAccess(input logic sel, input logic wr, input logic [31:0] d);
    @(negedge clk);
    hostSel = sel; hostWr = wr; hostRd = !wr; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    while (!hostReady) @(negedge clk);
  endtask

  task automatic readReg(input logic sel, output logic [31:0] v);
    hostSel = sel;
    #1;
    v = hostRdata;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    string tag;
    for (int k = 0; k < 16; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", {31'd0, hostReady}, 32'd1);
    check("R1 memReq", {31'd0, memReq}, 32'd0);
    check("R1 cpuIrq", {31'd0, cpuIrq}, 32'd0);
    readReg(1'b0, v); check("R1 address reg", v, 32'd0);
    readReg(1'b1, v); check("R1 data reg", v, 32'd0);

    // R2 address register readback
    hostAccess(1'b0, 1'b1, {30'h2AAA_5555, 1'b1, 1'b0});
    readReg(1'b0, v); check("R2 readback", v, {30'h2AAA_5555, 1'b1, 1'b0});

    // vector table: R3..R7
    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      asyncMode = VECS[i].am;
      tag = VECS[i].am ? (VECS[i].incOff ? "R6" : "R5") : "R7";
      hostAccess(1'b0, 1'b1, {VECS[i].addr, VECS[i].incOff, 1'b0});
      hostAccess(1'b1, 1'b1, VECS[i].data);
      check("R3 memory written", mem[VECS[i].addr[3:0]], VECS[i].data);
      readReg(1'b0, v); check({tag, " after write"}, v, {VECS[i].exp, VECS[i].incOff, 1'b0});
      hostAccess(1'b0, 1'b1, {VECS[i].addr, VECS[i].incOff, 1'b0});
      mem[VECS[i].addr[3:0]] = VECS[i].data ^ 32'hFFFF_0000;
      hostAccess(1'b1, 1'b0, 32'h0);
      readReg(1'b1, v); check("R4 read data", v, VECS[i].data ^ 32'hFFFF_0000);
      readReg(1'b0, v); check({tag, " after read"}, v, {VECS[i].exp, VECS[i].incOff, 1'b0});
    end

    // R10 / R11 / R3 stall: strobes during a long transfer
    lat = 6;
    asyncMode = 1'b1;
    hostAccess(1'b0, 1'b1, {30'd4, 1'b0, 1'b0});
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostWdata = 32'h5A5A_A5A5;
    @(negedge clk);
    hostWr = 1'b0;
    check("R3 ready low during transfer", {31'd0, hostReady}, 32'd0);
    hostSel = 1'b0; hostWr = 1'b1; hostWdata = {30'd100, 1'b1, 1'b1};
    @(negedge clk);
    check("R11 request held", {31'd0, memReq}, 32'd1);
    check("R11 address held", {2'b0, memAddr}, 32'd4);
    check("R11 write data held", memWdata, 32'h5A5A_A5A5);
    @(negedge clk);
    hostWr = 1'b0;
    while (!hostReady) @(negedge clk);
    readReg(1'b0, v); check("R10 busy strobe ignored", v, {30'd5, 1'b0, 1'b0});
    check("R10 no interrupt from ignored strobe", {31'd0, cpuIrq}, 32'd0);
    check("R3 memory written after stall", mem[4], 32'h5A5A_A5A5);
    lat = 0;

    // R8 host sets interrupt; writing 0 does not clear
    hostAccess(1'b0, 1'b1, {30'd2, 1'b0, 1'b1});
    check("R8 interrupt set", {31'd0, cpuIrq}, 32'd1);
    readReg(1'b0, v); check("R2 live irq bit", v, {30'd2, 1'b0, 1'b1});
    hostAccess(1'b0, 1'b1, {30'd2, 1'b0, 1'b0});
    check("R8 zero write keeps interrupt", {31'd0, cpuIrq}, 32'd1);

    // R9 processor clear
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    check("R9 clear", {31'd0, cpuIrq}, 32'd0);

    // R9 set and clear in the same cycle: set wins
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b1; hostWdata = {30'd2, 1'b0, 1'b1}; irqClr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; irqClr = 1'b0;
    check("R9 set wins collision", {31'd0, cpuIrq}, 32'd1);
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    check("R9 clear after collision", {31'd0, cpuIrq}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule